// File: doc/BRIEF.md
# Fixed-Size Block Packer for One Logical Link

This block takes a stream of variable-length packets from a single logical link and repacks it into fixed 1 KiB blocks (512 words of 16 bits) ready for bulk transfer to host memory. Packets arrive as 16-bit words with start, end and error markers. They leave as a 16-bit word stream with a valid/ready handshake and a marker on the final word of each block.

A block opens when data arrives. It starts with a two-word header that carries the link number, a rolling block counter and a fixed start-of-block symbol. Packet data is then copied into sub-chunks. Each sub-chunk is closed by a trailer word that records how the sub-chunk relates to its packet, any error or truncation, and its length. A packet that does not fit in the remaining space continues in the next block. If the link goes quiet for a programmable number of cycles, the open block is padded with zero words and closed with an empty-typed trailer, so that partial data still reaches the host.

Top module: `blk_packer`

## Requirements
- R1: Every block is exactly 512 output words long. `out_last` is high on the 512th word of each block and on no other word.
- R2: Output word 0 of a block is `{link_id[10:0], seq[4:0]}` and word 1 is the start symbol 16'hC35A. No input word is accepted while either header word is on the output. The block does not start before an input word is offered.
- R3: The 5-bit block counter is 0 in the first block after reset and advances by one for each block, wrapping modulo 32.
- R4: A trailer word holds the kind in bits 15:13, the error flag in bit 12, the truncation flag in bit 11, zeros in bits 10:9 and the number of data words in the sub-chunk in bits 8:0. The kind codes are empty=0, first=1, middle=2, last=3, whole=4.
- R5: A sub-chunk that holds a complete packet is of kind whole. One that opens a packet which continues is first, one that neither opens nor ends it is middle, and one that ends a packet begun in an earlier sub-chunk is last.
- R6: A data word is placed only where at least one word remains after it for a trailer. When the space left after a trailer is a single word, that word becomes an empty trailer of length 0 at once.
- R7: After `cfg_timeout` consecutive cycles in an open block with no input offered, any open sub-chunk is closed with a non-ending trailer. The rest of the block, except its last word, is then filled with zero words, and the last word is an empty trailer whose length is the number of zero words. A `cfg_timeout` of 0 disables this flush.
- R8: When `in_err` is high with `in_eop`, the trailer that ends that packet has bit 12 set. Otherwise bit 12 is clear.
- R9: When `cfg_max_len` is non-zero and a packet reaches that many words without an end, its sub-chunk ends there with an ending kind and bit 11 set. The rest of the packet, up to and including its end word, is consumed and discarded.
- R10: Under output backpressure, data words leave in arrival order with none lost or duplicated, and a stalled output word stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_id | input | 11 | Link number placed in each header |
| cfg_timeout | input | 16 | Idle cycles before an open block is flushed, 0 disables |
| cfg_max_len | input | 16 | Packet word limit before truncation, 0 disables |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | 16 | Input packet word |
| in_sop | input | 1 | Word opens a packet |
| in_eop | input | 1 | Word ends a packet |
| in_err | input | 1 | Packet transfer error, meaningful with in_eop |
| out_valid | output | 1 | Output word offered |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | 16 | Output block word |
| out_last | output | 1 | Final word of a block |

## Verification
The output-stability assertion assumes that the source holds `in_valid` and the input fields steady until a word is accepted. It also assumes that packets are well formed, each opened by `in_sop` and closed by `in_eop`. The bench driver keeps each word in place until it sees the acceptance, and it sends only well-formed packets, including those cut across blocks or left waiting for the timeout. The slot and header assertions rely only on the handshake, so the bench varies `out_ready` in a repeating pattern to stall the header, data, trailer and padding words.

// File: rtl/pk_pkg.sv
// Shared types for the block packer.
// Assumes: trailer length field is 9 bits, so blocks hold at most 512 words.
package pk_pkg;

    localparam int TRL_LEN_W = 9;

    // Sub-chunk kind carried in trailer bits 15:13.
    typedef enum logic [2:0] {
        SUB_NULL   = 3'd0,
        SUB_FIRST  = 3'd1,
        SUB_MIDDLE = 3'd2,
        SUB_LAST   = 3'd3,
        SUB_BOTH   = 3'd4
    } sub_kind_e;

    // Packer control states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR0,
        ST_HDR1,
        ST_DATA,
        ST_TRL,
        ST_PAD,
        ST_DROP
    } pk_state_e;

endpackage

// File: rtl/pk_pos_ctr.sv
// Word position inside the current output block.
// Counts accepted output words and wraps after the last word of a block.
// Assumes: step is only high on an output handshake.
module pk_pos_ctr #(
    parameter int BLK_WORDS = 512,
    localparam int POS_W = $clog2(BLK_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [POS_W-1:0] pos
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(BLK_WORDS - 1);

    // Advance on each output word, wrap at the block end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos <= '0;
        else if (step)
            pos <= (pos == LAST_POS) ? '0 : pos + 1'b1;
    end

endmodule

// File: rtl/pk_idle_tmr.sv
// Idle timer for an open block.
// Counts consecutive cycles with run high (saturating), clears when run drops.
// expired is high on the limit-th such cycle and after; limit 0 disables it.
module pk_idle_tmr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    // Count idle cycles, saturate at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt <= '0;
        else if (cnt != '1)
            cnt <= cnt + 1'b1;
    end

    // Compare against limit minus one so the limit-th idle cycle fires.
    always_comb expired = run && (limit != '0) && (cnt >= limit - 1'b1);

endmodule

// File: rtl/pk_trl_fmt.sv
// Trailer word encoder.
// Picks the sub-chunk kind from continuation and end status and packs
// kind, error, truncation and length into one 16-bit word.
module pk_trl_fmt
    import pk_pkg::*;
(
    input  logic                 is_null,
    input  logic                 cont,
    input  logic                 ended,
    input  logic                 err,
    input  logic                 trunc,
    input  logic [TRL_LEN_W-1:0] len,
    output logic [15:0]          word
);

    sub_kind_e kind;

    // Select the kind, then pack the fields.
    always_comb begin
        if (is_null)
            kind = SUB_NULL;
        else if (!cont)
            kind = ended ? SUB_BOTH : SUB_FIRST;
        else
            kind = ended ? SUB_LAST : SUB_MIDDLE;
        word = {kind, err, trunc, 2'b00, len};
    end

endmodule

// File: rtl/blk_packer.sv
// Packs one link's packets into fixed-size blocks with header, per-sub-chunk
// trailers, idle-timeout padding and packet truncation.
// Assumes: source holds in_valid and fields until accepted; packets are
// opened by in_sop and closed by in_eop.
module blk_packer
    import pk_pkg::*;
#(
    parameter int          BLOCK_BYTES = 1024,
    parameter int          LINK_W      = 11,
    parameter int          SEQ_W       = 5,
    parameter int          CFG_W       = 16,
    parameter logic [15:0] SOB_SYM     = 16'hC35A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINK_W-1:0] link_id,
    input  logic [CFG_W-1:0]  cfg_timeout,
    input  logic [CFG_W-1:0]  cfg_max_len,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [15:0]       in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              in_err,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [15:0]       out_data,
    output logic              out_last
);

    localparam int BLK_WORDS = BLOCK_BYTES / 2;
    localparam int POS_W     = $clog2(BLK_WORDS);
    localparam logic [POS_W-1:0] POS_END  = POS_W'(BLK_WORDS - 1);
    localparam logic [POS_W-1:0] POS_NEAR = POS_W'(BLK_WORDS - 2);

    pk_state_e             state;
    logic [SEQ_W-1:0]      seq;
    logic [POS_W-1:0]      pos;
    logic [TRL_LEN_W-1:0]  sub_len;
    logic [CFG_W-1:0]      pkt_len;
    logic                  in_pkt, blk_open;
    logic                  t_cont, t_end, t_err, t_trunc;
    logic                  drop_pend, to_pend;
    logic                  to_exp, out_fire, in_fire;
    logic                  at_end, near_end;
    logic                  cont_now, trunc_hit, pkt_ends;
    logic [CFG_W-1:0]      pkt_base;
    logic [15:0]           trl_word;

    pk_pos_ctr #(.BLK_WORDS(BLK_WORDS)) u_pos (
        .clk  (clk),
        .rst_n(rst_n),
        .step (out_fire),
        .pos  (pos)
    );

    pk_idle_tmr #(.CNT_W(CFG_W)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state == ST_DATA && !in_valid),
        .limit  (cfg_timeout),
        .expired(to_exp)
    );

    pk_trl_fmt u_fmt (
        .is_null(state == ST_PAD),
        .cont   (t_cont),
        .ended  (t_end),
        .err    (t_err),
        .trunc  (t_trunc),
        .len    (sub_len),
        .word   (trl_word)
    );

    // Position flags and per-word packet decisions.
    always_comb begin
        at_end    = (pos == POS_END);
        near_end  = (pos == POS_NEAR);
        cont_now  = in_pkt && !in_sop;
        pkt_base  = in_sop ? '0 : pkt_len;
        trunc_hit = (cfg_max_len != '0) && !in_eop &&
                    ({1'b0, pkt_base} + 1'b1 >= {1'b0, cfg_max_len});
        pkt_ends  = in_eop || trunc_hit;
    end

    // Output word and input acceptance per state.
    always_comb begin
        out_valid = 1'b0;
        out_data  = '0;
        in_ready  = 1'b0;
        unique case (state)
            ST_HDR0: begin out_valid = 1'b1; out_data = {link_id, seq}; end
            ST_HDR1: begin out_valid = 1'b1; out_data = SOB_SYM; end
            ST_DATA: if (!to_exp) begin
                out_valid = in_valid;
                out_data  = in_data;
                in_ready  = out_ready;
            end
            ST_TRL:  begin out_valid = 1'b1; out_data = trl_word; end
            ST_PAD:  begin out_valid = 1'b1; out_data = at_end ? trl_word : '0; end
            ST_DROP: in_ready = 1'b1;
            default: ;
        endcase
        out_last = out_valid && at_end;
        out_fire = out_valid && out_ready;
        in_fire  = in_valid && in_ready;
    end

    // Block, sub-chunk and packet sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            seq       <= '0;
            sub_len   <= '0;
            pkt_len   <= '0;
            in_pkt    <= 1'b0;
            blk_open  <= 1'b0;
            t_cont    <= 1'b0;
            t_end     <= 1'b0;
            t_err     <= 1'b0;
            t_trunc   <= 1'b0;
            drop_pend <= 1'b0;
            to_pend   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (in_valid) state <= ST_HDR0;
                ST_HDR0: if (out_fire) begin
                    state    <= ST_HDR1;
                    blk_open <= 1'b1;
                end
                ST_HDR1: if (out_fire) state <= ST_DATA;
                ST_DATA: begin
                    if (to_exp) begin
                        if (sub_len != '0) begin
                            state   <= ST_TRL;
                            t_end   <= 1'b0;
                            t_err   <= 1'b0;
                            t_trunc <= 1'b0;
                            to_pend <= 1'b1;
                        end else begin
                            state <= ST_PAD;
                        end
                    end else if (in_fire) begin
                        sub_len <= sub_len + 1'b1;
                        if (sub_len == '0) t_cont <= cont_now;
                        in_pkt  <= !pkt_ends;
                        pkt_len <= pkt_ends ? '0 : pkt_base + 1'b1;
                        if (pkt_ends || near_end) begin
                            state     <= ST_TRL;
                            t_end     <= pkt_ends;
                            t_err     <= in_eop && in_err;
                            t_trunc   <= trunc_hit;
                            drop_pend <= trunc_hit;
                        end
                    end
                end
                ST_TRL: if (out_fire) begin
                    sub_len <= '0;
                    t_err   <= 1'b0;
                    t_trunc <= 1'b0;
                    to_pend <= 1'b0;
                    if (drop_pend)                state <= ST_DROP;
                    else if (at_end)              state <= ST_IDLE;
                    else if (to_pend || near_end) state <= ST_PAD;
                    else                          state <= ST_DATA;
                end
                ST_PAD: if (out_fire) begin
                    if (at_end) begin
                        state   <= ST_IDLE;
                        sub_len <= '0;
                    end else begin
                        sub_len <= sub_len + 1'b1;
                    end
                end
                ST_DROP: if (in_fire && in_eop) begin
                    drop_pend <= 1'b0;
                    if (!blk_open)   state <= ST_IDLE;
                    else if (at_end) state <= ST_PAD;
                    else             state <= ST_DATA;
                end
                default: state <= ST_IDLE;
            endcase
            if (out_fire && at_end) begin
                blk_open <= 1'b0;
                seq      <= seq + 1'b1;
            end
        end
    end

    // ---------------- assertions ----------------
    logic [POS_W-1:0] sh_cnt;
    logic [SEQ_W-1:0] sh_seq;

    // Port-side shadow of block position and counter for the checks below.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_cnt <= '0;
            sh_seq <= '0;
        end else if (out_valid && out_ready) begin
            sh_cnt <= out_last ? '0 : sh_cnt + 1'b1;
            if (out_last) sh_seq <= sh_seq + 1'b1;
        end
    end

    p_block_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |-> (sh_cnt == POS_END));

    p_hdr_no_input_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && sh_cnt <= POS_W'(1)) |-> !in_ready);

    p_seq_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && sh_cnt == '0) |-> (out_data[SEQ_W-1:0] == sh_seq));

    p_data_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && out_valid) |-> (sh_cnt <= POS_NEAR));

    p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: tb/test_blk_packer.sv
module test_blk_packer;

    localparam int CLK_P = 10;
    localparam int BLK   = 512;
    localparam int CAP   = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] link_id = 11'h2A5;
    logic [15:0] cfg_timeout = 16'd40;
    logic [15:0] cfg_max_len = 16'd0;
    logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_err = 1'b0;
    logic [15:0] in_data = '0;
    logic        in_ready, out_valid, out_last;
    logic        out_ready = 1'b1;
    logic [15:0] out_data;

    int   n_chk = 0, n_fail = 0;
    int   cap_n = 0, n_last = 0, cyc = 0;
    logic [15:0] cap_w [CAP];
    logic        cap_l [CAP];
    logic        in_fire = 1'b0;
    bit          bp_on = 1'b0;
    logic [4:0]  eseq = '0;

    blk_packer i_blk_packer (
        .clk(clk), .rst_n(rst_n), .link_id(link_id),
        .cfg_timeout(cfg_timeout), .cfg_max_len(cfg_max_len),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop), .in_err(in_err),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last)
    );

    always #(CLK_P/2) clk = ~clk;

    // Input handshake seen at each edge; output capture.
    always @(posedge clk) begin
        in_fire <= in_valid && in_ready;
        cyc <= cyc + 1;
        if (rst_n && out_valid && out_ready) begin
            if (cap_n < CAP) begin
                cap_w[cap_n] = out_data;
                cap_l[cap_n] = out_last;
            end
            cap_n = cap_n + 1;
            if (out_last) n_last = n_last + 1;
        end
    end

    // Repeating backpressure pattern.
    always @(negedge clk) out_ready <= bp_on ? (cyc % 3 != 2) : 1'b1;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] trl(input int kind, input bit err,
                                         input bit trunc, input int len);
        return {3'(kind), err, trunc, 2'b00, 9'(len)};
    endfunction

    // Words [start, start+n) must equal base, base+step, ...
    task automatic chk_run(input string req, input string what, input int start,
                           input int n, input logic [15:0] base, input int step);
        logic [15:0] a = '0, e = '0;
        bit bad = 0;
        for (int i = 0; i < n; i++) begin
            if (!bad && cap_w[start+i] !== base + 16'(i*step)) begin
                bad = 1; a = cap_w[start+i]; e = base + 16'(i*step);
            end
        end
        check(req, what, a, e);
    endtask

    // Header of block b and its end marker; advances the expected counter.
    task automatic chk_hdr(input int b);
        check("R2", "header word 0", cap_w[b*BLK], {link_id, eseq});
        check("R2", "header word 1", cap_w[b*BLK+1], 16'hC35A);
        check("R3", "block counter", cap_w[b*BLK][4:0], eseq);
        check("R1", "end marker", cap_l[b*BLK+BLK-1], 1'b1);
        eseq = eseq + 1'b1;
    endtask

    // Padding after a trailer at slot p of block b.
    task automatic chk_pad(input string req, input int b, input int p);
        chk_run(req, "zero padding", b*BLK+p+1, BLK-2-p, 16'h0, 0);
        check(req, "empty trailer", cap_w[b*BLK+BLK-1], trl(0, 0, 0, BLK-2-p));
    endtask

    task automatic send(input int n, input logic [15:0] base, input bit sop,
                        input bit eop, input bit err);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1;
            in_data  = base + 16'(i);
            in_sop   = sop && (i == 0);
            in_eop   = eop && (i == n-1);
            in_err   = err && (i == n-1);
            do begin @(posedge clk); @(negedge clk); end while (!in_fire);
        end
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_err = 1'b0;
    endtask

    task automatic wait_blocks(input int k);
        while (n_last < k) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic start_case();
        cap_n = 0; n_last = 0;
    endtask

    task automatic t_reset();
        check("R2", "no output after reset", out_valid, 1'b0);
        check("R2", "no input taken after reset", in_ready, 1'b0);
    endtask

    // Short packet under backpressure, flushed by timeout.
    task automatic t_short();
        start_case(); bp_on = 1;
        send(5, 16'h1000, 1, 1, 0);
        wait_blocks(1);
        bp_on = 0;
        check("R1", "block word count", cap_n, BLK);
        check("R1", "single end marker", n_last, 1);
        chk_hdr(0);
        chk_run("R10", "data order under stall", 2, 5, 16'h1000, 1);
        check("R4", "whole trailer", cap_w[7], trl(4, 0, 0, 5));
        chk_pad("R7", 0, 7);
    endtask

    // Error flag on the ending trailer.
    task automatic t_error();
        start_case();
        send(3, 16'h2000, 1, 1, 1);
        wait_blocks(1);
        chk_hdr(0);
        check("R8", "error flag set", cap_w[5], trl(4, 1, 0, 3));
        chk_pad("R7", 0, 5);
    endtask

    // Packet across three blocks: first, middle, last.
    task automatic t_span();
        start_case();
        send(1100, 16'h4000, 1, 1, 0);
        wait_blocks(3);
        chk_hdr(0); chk_hdr(1); chk_hdr(2);
        chk_run("R10", "block A data", 2, 509, 16'h4000, 1);
        check("R5", "first kind", cap_w[511], trl(1, 0, 0, 509));
        chk_run("R10", "block B data", BLK+2, 509, 16'h4000 + 16'd509, 1);
        check("R5", "middle kind", cap_w[BLK+511], trl(2, 0, 0, 509));
        chk_run("R10", "block C data", 2*BLK+2, 82, 16'h4000 + 16'd1018, 1);
        check("R5", "last kind", cap_w[2*BLK+84], trl(3, 0, 0, 82));
        chk_pad("R7", 2, 84);
        check("R1", "three blocks", cap_n, 3*BLK);
    endtask

    // Trailer leaves one slot: empty trailer of length 0 follows.
    task automatic t_edge_full();
        start_case();
        send(508, 16'h6000, 1, 1, 0);
        wait_blocks(1);
        chk_hdr(0);
        check("R5", "whole 508", cap_w[510], trl(4, 0, 0, 508));
        check("R6", "empty trailer length 0", cap_w[511], trl(0, 0, 0, 0));
    endtask

    // Two slots left: one data word then a first trailer.
    task automatic t_edge_split();
        start_case();
        send(507, 16'h7000, 1, 1, 0);
        send(5, 16'h8000, 1, 1, 0);
        wait_blocks(2);
        chk_hdr(0); chk_hdr(1);
        check("R6", "single word sub-chunk", cap_w[510], 16'h8000);
        check("R6", "first trailer len 1", cap_w[511], trl(1, 0, 0, 1));
        chk_run("R10", "continued data", BLK+2, 4, 16'h8001, 1);
        check("R5", "last len 4", cap_w[BLK+6], trl(3, 0, 0, 4));
        chk_pad("R7", 1, 6);
    endtask

    // Truncation: 10 of 15 words kept, rest dropped.
    task automatic t_trunc();
        start_case(); cfg_max_len = 16'd10;
        send(15, 16'h9000, 1, 1, 0);
        send(2, 16'hA000, 1, 1, 0);
        wait_blocks(1);
        cfg_max_len = 16'd0;
        chk_hdr(0);
        chk_run("R9", "kept words", 2, 10, 16'h9000, 1);
        check("R9", "truncated trailer", cap_w[12], trl(4, 0, 1, 10));
        chk_run("R9", "next packet follows drop", 13, 2, 16'hA000, 1);
        check("R5", "whole after drop", cap_w[15], trl(4, 0, 0, 2));
        chk_pad("R7", 0, 15);
    endtask

    // Timeout disabled, then enabled.
    task automatic t_to_off();
        start_case(); cfg_timeout = 16'd0;
        send(3, 16'hB000, 1, 1, 0);
        repeat (300) @(negedge clk);
        check("R7", "no flush when disabled", cap_n, 6);
        cfg_timeout = 16'd40;
        wait_blocks(1);
        chk_hdr(0);
        chk_pad("R7", 0, 5);
    endtask

    // Timeout in the middle of a packet.
    task automatic t_to_mid();
        start_case();
        send(3, 16'hC000, 1, 0, 0);
        wait_blocks(1);
        chk_hdr(0);
        check("R7", "open sub-chunk closed as first", cap_w[5], trl(1, 0, 0, 3));
        chk_pad("R7", 0, 5);
        send(2, 16'hC003, 0, 1, 0);
        wait_blocks(2);
        chk_hdr(1);
        chk_run("R10", "resumed data", BLK+2, 2, 16'hC003, 1);
        check("R5", "resumed as last", cap_w[BLK+4], trl(3, 0, 0, 2));
        chk_pad("R7", 1, 4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_short();
        t_error();
        t_span();
        t_edge_full();
        t_edge_split();
        t_trunc();
        t_to_off();
        t_to_mid();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule